// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO bank

This block is one bank of general-purpose I/O pins seen by software through a small word-addressed register bus. Software sets each pin's direction and output level. It reads back the synchronised state of every pad. For each pin it picks one of four interrupt conditions: rising edge, falling edge, high level or low level. Detected conditions latch into a status register. Any status bit whose pin is unmasked drives a single combined interrupt line, so a handler can scan the status word from bit 0 upward.

Each register is reached at three addresses. The plain address replaces the whole word. The set address raises only the bits that are 1 in the write data. The clear address lowers only the bits that are 1 in the write data. Single pins can therefore be changed without a read-modify-write. The bus address is `{index[2:0], access[1:0]}`. The access codes are 0 = plain, 1 = set, 2 = clear and 3 = no write. Reads at any of the four codes return the register named by the index. The indices are:

- 0: output data
- 1: output enable
- 2: pad input (read-only)
- 3: interrupt enable
- 4: interrupt routing
- 5: level select
- 6: polarity
- 7: status

`rst_n` is asserted asynchronously. It is expected to be already synchronised to `clk` on release.

Top module: `gpio_irq_bank`

## Requirements
- R1: A write at the plain code (access 0) to index 0, 1, 3, 4, 5 or 6 replaces all 32 bits of that register on the next clock. A read returns the register whose index is in `bus_addr[4:2]`, whatever the access code in `bus_addr[1:0]`.
- R2: A write at the set code (1) makes each bit that is 1 in `bus_wdata` equal to 1. A write at the clear code (2) makes each bit that is 1 in `bus_wdata` equal to 0. Bits that are 0 in `bus_wdata` keep their value.
- R3: `pad_oe` equals the output-enable register and `pad_out` equals the output-data register, bit n for pin n.
- R4: Index 2 reads `pad_in` as it was two clock edges earlier, regardless of pin direction. Writes to index 2 at any access code have no effect.
- R5: With level bit 0, polarity 1 selects a rising edge and polarity 0 selects a falling edge. A pad change that matches sets the pin's status bit on the third clock edge after the change.
- R6: With level bit 1, polarity 1 means active high and polarity 0 means active low. The status bit is set on every clock while the synchronised pad is at the active level, so it cannot be cleared until that level goes away.
- R7: A write at the clear code of index 7 clears the status bits that are 1 in `bus_wdata`. Plain and set writes to index 7 have no effect. If a clear and a new event for the same pin fall on the same clock, the bit stays 1.
- R8: `irq_out` is 1 exactly when some pin has its status bit, its interrupt-enable bit and its routing bit all equal to 1.
- R9: After reset every register reads 0, every pin is an input and `irq_out` is 0.
- R10: A write at access code 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register index (bits 4:2) and access code (bits 1:0) |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register selected by `bus_addr` |
| pad_in | input | 32 | Pad input levels, may be asynchronous |
| pad_out | output | 32 | Output levels to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_out | output | 1 | Combined bank interrupt |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `bus_wdata` are settled at each rising edge, so that a write is captured on exactly one edge. They also assume that `pad_in` does not change during the edge at which it is sampled, so that the two-edge delay to the input register is exact. The stimulus changes every input one nanosecond after a falling edge. Each write strobe is held for exactly one rising edge. Pad changes fall on arbitrary cycles, including the same cycle as status clears, so that the rule that a new event wins over a clear is reached.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int IDX_W    = 3;
  localparam int ALIAS_W  = 2;
  localparam int ADDR_W   = IDX_W + ALIAS_W;
  localparam int NUM_REGS = 1 << IDX_W;

  // register indices; the bus decodes these positions
  typedef enum logic [IDX_W-1:0] {
    REG_DOUT  = 3'd0,
    REG_DOE   = 3'd1,
    REG_DIN   = 3'd2,
    REG_IEN   = 3'd3,
    REG_ROUTE = 3'd4,
    REG_LEVEL = 3'd5,
    REG_POL   = 3'd6,
    REG_STAT  = 3'd7
  } reg_sel_e;

  // access kinds carried in the low address bits
  typedef enum logic [ALIAS_W-1:0] {
    ACC_WRITE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_NONE  = 2'd3
  } access_e;
endpackage

// File: rtl/gpio_reg_cell.sv
module gpio_reg_cell
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_sel,
  input  access_e      wr_access,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    en = wr_sel;
    d  = q;
    unique case (wr_access)
      ACC_WRITE: d = wr_data;
      ACC_SET:   d = q | wr_data;
      ACC_CLR:   d = q & ~wr_data;
      default: begin
        d  = q;
        en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage1_d;
  logic [W-1:0] stage2_d;

  always_comb begin
    stage1_d = async_in;
    stage2_d = stage1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      sync_out <= '0;
    end else begin
      stage1_q <= stage1_d;
      sync_out <= stage2_d;
    end
  end
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_now,
  input  logic [W-1:0] level_sel,
  input  logic [W-1:0] pol_sel,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] event_hit,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] at_active;
  logic [W-1:0] changed;
  logic [W-1:0] stat_d;

  always_comb begin
    at_active = ~(pin_now ^ pol_sel);
    changed   = pin_now ^ prev_q;
    // edge mode needs a change into the active value; level mode only the value
    event_hit = (level_sel & at_active) | (~level_sel & changed & at_active);
    // a fresh event overrides a clear on the same clock
    stat_d    = (stat_q & ~clr_mask) | event_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= pin_now;
      stat_q <= stat_d;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_out
);
  logic [IDX_W-1:0]              acc_idx;
  access_e                       acc_kind;
  logic [NUM_REGS-1:0][NPINS-1:0] reg_view;
  logic [NPINS-1:0]              din_q;
  logic [NPINS-1:0]              stat_q;
  logic [NPINS-1:0]              event_hit;
  logic [NPINS-1:0]              stat_clr;
  logic [NPINS-1:0]              ien_q;
  logic [NPINS-1:0]              route_q;

  assign acc_idx  = bus_addr[ADDR_W-1:ALIAS_W];
  assign acc_kind = access_e'(bus_addr[ALIAS_W-1:0]);

  gpio_pad_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (din_q)
  );

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    if (gi == int'(REG_DIN)) begin : g_din
      assign reg_view[gi] = din_q;
    end else if (gi == int'(REG_STAT)) begin : g_stat
      assign reg_view[gi] = stat_q;
    end else begin : g_cell
      gpio_reg_cell #(.W(NPINS)) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (bus_we && (acc_idx == IDX_W'(gi))),
        .wr_access (acc_kind),
        .wr_data   (bus_wdata),
        .q         (reg_view[gi])
      );
    end
  end

  assign stat_clr = (bus_we && (acc_idx == REG_STAT) && (acc_kind == ACC_CLR))
                    ? bus_wdata : '0;

  gpio_event_unit #(.W(NPINS)) u_event (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_now   (din_q),
    .level_sel (reg_view[REG_LEVEL]),
    .pol_sel   (reg_view[REG_POL]),
    .clr_mask  (stat_clr),
    .event_hit (event_hit),
    .stat_q    (stat_q)
  );

  assign ien_q     = reg_view[REG_IEN];
  assign route_q   = reg_view[REG_ROUTE];
  assign pad_out   = reg_view[REG_DOUT];
  assign pad_oe    = reg_view[REG_DOE];
  assign irq_out   = |(stat_q & ien_q & route_q);
  assign bus_rdata = reg_view[acc_idx];
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       bus_addr,
  input logic             bus_we,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq_out,
  input logic [NPINS-1:0] din_q,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] event_hit,
  input logic [NPINS-1:0] ien_q
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'b001_01) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'b001_10) |=> ((pad_oe & $past(bus_wdata)) == '0));

  assert_din_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (din_q == $past(pad_in, 2)));

  assert_masked_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_out);

  assert_status_from_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1) |-> ((stat_q & ~$past(stat_q) & ~$past(event_hit)) == '0));

  assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'b111_10) |=> ((stat_q & $past(bus_wdata) & ~$past(event_hit)) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pad_in    (pad_in),
  .pad_oe    (pad_oe),
  .irq_out   (irq_out),
  .din_q     (din_q),
  .stat_q    (stat_q),
  .event_hit (event_hit),
  .ien_q     (ien_q)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [8];
  logic [31:0] pad_hist [$];   // [0] newest sample

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      pad_hist = '{32'h0, 32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] ev;
      logic [31:0] clr;
      int idx;
      int acc;
      ev  = '0;
      clr = '0;
      idx = int'(bus_addr[4:2]);
      acc = int'(bus_addr[1:0]);
      for (int p = 0; p < 32; p++) begin
        bit cur, old;
        cur = pad_hist[1][p];
        old = pad_hist[2][p];
        if (m_reg[5][p]) ev[p] = (cur == m_reg[6][p]);
        else if (m_reg[6][p]) ev[p] = (!old && cur);
        else ev[p] = (old && !cur);
      end
      if (bus_we) begin
        if (idx == 7) begin
          if (acc == 2) clr = bus_wdata;
        end else if (idx != 2) begin
          if (acc == 0) m_reg[idx] = bus_wdata;
          else if (acc == 1) m_reg[idx] = m_reg[idx] | bus_wdata;
          else if (acc == 2) m_reg[idx] = m_reg[idx] & ~bus_wdata;
        end
      end
      for (int p = 0; p < 32; p++) begin
        if (ev[p]) m_reg[7][p] = 1'b1;
        else if (clr[p]) m_reg[7][p] = 1'b0;
      end
      pad_hist.push_front(pad_in);
      void'(pad_hist.pop_back());
    end
  end

  function automatic logic [31:0] model_read(int idx);
    if (idx == 2) return pad_hist[1];
    return m_reg[idx];
  endfunction

  function automatic string tag_of(int idx);
    if (idx == 2) return "R4";
    if (idx == 7) return "R5/R6/R7";
    return "R1/R2/R10";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison, before inputs move
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] irq_exp;
      irq_exp = {31'b0, |(m_reg[7] & m_reg[3] & m_reg[4])};
      check("R3 pad_out", pad_out, m_reg[0]);
      check("R3 pad_oe", pad_oe, m_reg[1]);
      check("R8 irq_out", {31'b0, irq_out}, irq_exp);
      check(tag_of(int'(bus_addr[4:2])), bus_rdata, model_read(int'(bus_addr[4:2])));
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic read_expect(string tag, logic [4:0] a, logic [31:0] exp);
    @(negedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic set_pad(logic [31:0] v);
    @(negedge clk); #1;
    pad_in = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    for (int i = 0; i < 8; i++) read_expect("R9 reset value", 5'(i << 2), 32'h0);
    check("R9 reset pad_oe", pad_oe, 32'h0);
    check("R9 reset irq", {31'b0, irq_out}, 32'h0);

    // R1 plain writes, R3 outputs
    bus_write({3'd1, 2'd0}, 32'hF0F0_F0F0);
    check("R3 pad_oe after write", pad_oe, 32'hF0F0_F0F0);
    bus_write({3'd0, 2'd0}, 32'hA5A5_A5A5);
    read_expect("R1 read via clr code", {3'd0, 2'd2}, 32'hA5A5_A5A5);
    // R2 set/clear aliases
    bus_write({3'd0, 2'd0}, 32'h0);
    bus_write({3'd0, 2'd1}, 32'h0000_00FF);
    bus_write({3'd0, 2'd2}, 32'h0000_000F);
    read_expect("R2 set then clear", {3'd0, 2'd0}, 32'h0000_00F0);
    check("R3 pad_out", pad_out, 32'h0000_00F0);
    // R10 ignored access code
    bus_write({3'd0, 2'd3}, 32'hFFFF_FFFF);
    read_expect("R10 no-write code", {3'd0, 2'd0}, 32'h0000_00F0);

    // R4 input path
    set_pad(32'h1234_5678);
    idle(3);
    bus_write({3'd2, 2'd0}, 32'hFFFF_FFFF);
    read_expect("R4 pad sample", {3'd2, 2'd0}, 32'h1234_5678);

    // interrupt set-up: pin0 rise, pin1 fall, pin2 high, pin3 low
    set_pad(32'h0);
    idle(4);
    bus_write({3'd5, 2'd0}, 32'h0000_000C);
    bus_write({3'd6, 2'd0}, 32'h0000_0005);
    bus_write({3'd7, 2'd2}, 32'hFFFF_FFFF);
    read_expect("R6 low level re-sets", {3'd7, 2'd0}, 32'h0000_0008);
    check("R8 no irq while disabled", {31'b0, irq_out}, 32'h0);
    bus_write({3'd3, 2'd1}, 32'h0000_000F);
    check("R8 route still masks", {31'b0, irq_out}, 32'h0);
    bus_write({3'd4, 2'd1}, 32'h0000_000F);
    check("R8 irq with both enables", {31'b0, irq_out}, 32'h1);

    set_pad(32'h0000_000D);
    idle(5);
    bus_write({3'd7, 2'd2}, 32'hFFFF_FFFF);
    read_expect("R5/R6 edge cleared, level held", {3'd7, 2'd0}, 32'h0000_0004);
    set_pad(32'h0000_000F);
    idle(2);
    set_pad(32'h0000_000D);
    idle(5);
    read_expect("R5 falling edge", {3'd7, 2'd0}, 32'h0000_0006);
    bus_write({3'd7, 2'd0}, 32'h0);
    bus_write({3'd7, 2'd1}, 32'hFFFF_FFFF);
    read_expect("R7 plain/set ignored", {3'd7, 2'd0}, 32'h0000_0006);

    // randomised traffic, checked every clock against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      bus_addr  = 5'($urandom_range(0, 31));
      bus_we    = ($urandom_range(0, 2) == 0);
      bus_wdata = $urandom();
      if ($urandom_range(0, 3) == 0) pad_in = pad_in ^ (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 15) == 0) pad_in = $urandom();
    end
    @(negedge clk); #1 bus_we = 1'b0;
    idle(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule